// File: doc/BRIEF.md
# Breakpoint Clock-Gating Debug Controller

This block sits between a free-running system clock and a circuit under debug. It owns the clock enable that the target's registers use, so it can stop the target on any cycle and restart it later. While the target is frozen, none of its registers change. The target is never reset to stop it.

A host writes commands and configuration through a small register port. It can start a run, which passes a start pulse to the target, and it can force a halt. It can also arm a value breakpoint. A multiplexer picks one of the target's output buses, and an equality comparator checks it against a programmed value. When the two are equal, the enable drops in that same cycle, so the target stops holding the matching value. A resume command restarts the target. Value matching is ignored for the first delivered cycle after a resume, so a value that has not changed does not stop the target again at once. A saturating counter counts every clock cycle delivered to the target. The target's done output ends the run and is reported back to the host as a status flag.

Register map, selected by `host_addr_i`:

| Address | Write | Read |
| --- | --- | --- |
| 0 | command bits | status |
| 1 | configuration | configuration |
| 2 | compare value | compare value |
| 3 | (none) | cycle count |

Top module: `bp_clk_ctrl`

## Requirements
- R1: After reset, the following all hold. The status reads run state 0 (IDLE) with the done flag clear. The cycle count, configuration and compare value all read 0. `tgt_clk_en_o` and `tgt_start_o` are low.
- R2: A write to address 0 with bit 0 set starts a run. It is accepted in any state, and it takes priority over the other command bits. On the next cycle the following hold:
  - the run state is 1 (RUN);
  - the count is 0;
  - the done flag is clear;
  - `tgt_start_o` is high, and it stays high until one target cycle has been delivered.
- R3: `tgt_clk_en_o` is high only in RUN, and only in a cycle that has no breakpoint hit and no halt command. It is always low in IDLE and in HALTED (state 2).
- R4: With configuration bit 8 set, the following applies in RUN. If the selected probe equals the compare value, `tgt_clk_en_o` drops in that same cycle and the state becomes HALTED on the next cycle. The target then holds the matching value.
- R5: Configuration bits [SEL_W-1:0] select probe lane k, which is `tgt_probe_i[k*PROBE_W +: PROBE_W]`. A select value at or above N_PROBE watches zero.
- R6: A write to address 0 with bit 2 set in RUN gates the enable in that cycle and moves the state to HALTED. The same write in IDLE or HALTED has no effect.
- R7: In HALTED, no target cycle is delivered and the count stays fixed. This lasts until a resume or a start.
- R8: A write to address 0 with bit 1 set in HALTED moves the state to RUN on the next cycle. The first delivered cycle after that ignores a value match. The same write in IDLE or RUN has no effect.
- R9: The count increments on each cycle in which `tgt_clk_en_o` is high. It saturates at 2^CNT_W-1 and reads back at address 3.
- R10: `tgt_done_i` in RUN, while `tgt_start_o` is low, moves the state to IDLE and sets status bit 2. Done wins over a breakpoint hit in the same cycle.
- R11: Clearing configuration bit 8 turns off value matching. The select field and the compare value still read back unchanged.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 2 | Register address, used for both write and read |
| host_wdata_i | input | HOST_W | Host write data |
| host_rdata_o | output | HOST_W | Combinational read data for `host_addr_i` |
| tgt_clk_en_o | output | 1 | Clock enable for the target's registers |
| tgt_start_o | output | 1 | Start request to the target |
| tgt_done_i | input | 1 | Done flag from the target |
| tgt_probe_i | input | N_PROBE*PROBE_W | Target output buses that can be watched |

## Verification
The bench drives a counting target model that only advances on enabled cycles. It goes after the following corner cases.

- **Halt on the matching value.** The breakpoint must stop the target while it holds the matching value. A registered gate would let the target run one value past the breakpoint.
- **Resume on an unchanged match.** After a resume, the probe still equals the compare value. Without the mask, the target would halt again without moving.
- **Saturation of the count.** A run longer than the count range checks that the counter stops at its maximum. A wrapping counter would read back a small value.
- **Ignored commands.** Resume and halt are written in states where they must do nothing.
- **Disable bit.** Clearing the enable must leave the select and the compare value intact.
- **Restart from a halt.** A start written in HALTED must clear the count and restart the target.

// File: rtl/bp_dbg_pkg.sv
package bp_dbg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } run_state_e;

  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CMD = 2'd0;
  localparam logic [ADDR_W-1:0] A_CFG = 2'd1;
  localparam logic [ADDR_W-1:0] A_BPV = 2'd2;
  localparam logic [ADDR_W-1:0] A_CNT = 2'd3;

  localparam int unsigned CMD_START  = 0;
  localparam int unsigned CMD_RESUME = 1;
  localparam int unsigned CMD_HALT   = 2;
  localparam int unsigned CFG_EN_BIT = 8;
  localparam int unsigned STS_DONE   = 2;
endpackage

// File: rtl/bp_probe_mux.sv
module bp_probe_mux #(
  parameter int unsigned N_PROBE = 4,
  parameter int unsigned PROBE_W = 16,
  parameter int unsigned SEL_W   = 2
) (
  input  logic [N_PROBE*PROBE_W-1:0] probes_i,
  input  logic [SEL_W-1:0]           sel_i,
  output logic [PROBE_W-1:0]         watch_o
);
  logic [PROBE_W-1:0] lane [N_PROBE];

  for (genvar g = 0; g < N_PROBE; g++) begin : g_lane
    assign lane[g] = probes_i[g*PROBE_W +: PROBE_W];
  end

  // out-of-range select watches zero
  always_comb begin
    watch_o = '0;
    for (int i = 0; i < N_PROBE; i++) begin
      if (sel_i == SEL_W'(i)) watch_o = lane[i];
    end
  end
endmodule

// File: rtl/bp_match.sv
module bp_match #(
  parameter int unsigned PROBE_W = 16
) (
  input  logic [PROBE_W-1:0] watch_i,
  input  logic [PROBE_W-1:0] ref_i,
  input  logic               en_i,
  input  logic               mask_i,
  output logic               hit_o
);
  assign hit_o = en_i && !mask_i && (watch_i == ref_i);
endmodule

// File: rtl/bp_cycle_cnt.sv
module bp_cycle_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (clr_i)                   cnt_o <= '0;
    else if (inc_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/bp_run_fsm.sv
module bp_run_fsm
  import bp_dbg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       resume_i,
  input  logic       halt_i,
  input  logic       hit_i,
  input  logic       done_i,
  output run_state_e state_o,
  output logic       clk_en_o,
  output logic       tgt_start_o,
  output logic       mask_o,
  output logic       done_flag_o
);
  run_state_e state_d;
  logic       is_run, is_halt, done_eff;

  assign is_run   = (state_o == ST_RUN);
  assign is_halt  = (state_o == ST_HALT);
  // done is stale until the target has taken its start edge
  assign done_eff = done_i && !tgt_start_o;
  // combinational gate: the matching value is never clocked past
  assign clk_en_o = is_run && !hit_i && !halt_i;

  always_comb begin
    state_d = state_o;
    if (start_i) begin
      state_d = ST_RUN;
    end else begin
      unique case (state_o)
        ST_RUN: begin
          if (done_eff)            state_d = ST_IDLE;
          else if (hit_i || halt_i) state_d = ST_HALT;
        end
        ST_HALT: if (resume_i) state_d = ST_RUN;
        default: state_d = state_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o     <= ST_IDLE;
      tgt_start_o <= 1'b0;
      mask_o      <= 1'b0;
      done_flag_o <= 1'b0;
    end else begin
      state_o <= state_d;

      if (start_i)       tgt_start_o <= 1'b1;
      else if (clk_en_o) tgt_start_o <= 1'b0;

      if (start_i)                  mask_o <= 1'b0;
      else if (is_halt && resume_i) mask_o <= 1'b1;
      else if (clk_en_o)            mask_o <= 1'b0;

      if (start_i)                done_flag_o <= 1'b0;
      else if (is_run && done_eff) done_flag_o <= 1'b1;
    end
  end
endmodule

// File: rtl/bp_clk_ctrl.sv
module bp_clk_ctrl
  import bp_dbg_pkg::*;
#(
  parameter int unsigned N_PROBE = 4,
  parameter int unsigned PROBE_W = 16,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned HOST_W  = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       host_wr_i,
  input  logic [1:0]                 host_addr_i,
  input  logic [HOST_W-1:0]          host_wdata_i,
  output logic [HOST_W-1:0]          host_rdata_o,
  output logic                       tgt_clk_en_o,
  output logic                       tgt_start_o,
  input  logic                       tgt_done_i,
  input  logic [N_PROBE*PROBE_W-1:0] tgt_probe_i
);
  localparam int unsigned SEL_W = (N_PROBE > 1) ? $clog2(N_PROBE) : 1;

  logic               start_cmd, resume_cmd, halt_cmd, cmd_wr;
  logic [SEL_W-1:0]   sel_q;
  logic               bp_en_q;
  logic [PROBE_W-1:0] bp_val_q, watch;
  logic               hit, mask, done_flag;
  logic [CNT_W-1:0]   cycle_cnt;
  run_state_e         run_state;
  logic               unused_wdata;

  assign unused_wdata = ^host_wdata_i;

  assign cmd_wr     = host_wr_i && (host_addr_i == A_CMD);
  assign start_cmd  = cmd_wr && host_wdata_i[CMD_START];
  assign resume_cmd = cmd_wr && host_wdata_i[CMD_RESUME];
  assign halt_cmd   = cmd_wr && host_wdata_i[CMD_HALT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= '0;
      bp_en_q  <= 1'b0;
      bp_val_q <= '0;
    end else if (host_wr_i) begin
      if (host_addr_i == A_CFG) begin
        sel_q   <= host_wdata_i[SEL_W-1:0];
        bp_en_q <= host_wdata_i[CFG_EN_BIT];
      end
      if (host_addr_i == A_BPV) bp_val_q <= host_wdata_i[PROBE_W-1:0];
    end
  end

  bp_probe_mux #(
    .N_PROBE(N_PROBE), .PROBE_W(PROBE_W), .SEL_W(SEL_W)
  ) u_mux (
    .probes_i(tgt_probe_i), .sel_i(sel_q), .watch_o(watch)
  );

  bp_match #(.PROBE_W(PROBE_W)) u_match (
    .watch_i(watch), .ref_i(bp_val_q), .en_i(bp_en_q),
    .mask_i(mask), .hit_o(hit)
  );

  bp_run_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(start_cmd), .resume_i(resume_cmd), .halt_i(halt_cmd),
    .hit_i(hit), .done_i(tgt_done_i),
    .state_o(run_state), .clk_en_o(tgt_clk_en_o),
    .tgt_start_o(tgt_start_o), .mask_o(mask), .done_flag_o(done_flag)
  );

  bp_cycle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(start_cmd), .inc_i(tgt_clk_en_o), .cnt_o(cycle_cnt)
  );

  always_comb begin
    host_rdata_o = '0;
    unique case (host_addr_i)
      A_CMD: begin
        host_rdata_o[1:0]      = run_state;
        host_rdata_o[STS_DONE] = done_flag;
      end
      A_CFG: begin
        host_rdata_o[SEL_W-1:0]  = sel_q;
        host_rdata_o[CFG_EN_BIT] = bp_en_q;
      end
      A_BPV:   host_rdata_o[PROBE_W-1:0] = bp_val_q;
      default: host_rdata_o[CNT_W-1:0]   = cycle_cnt;
    endcase
  end
endmodule

// File: rtl/bp_clk_ctrl_chk.sv
module bp_clk_ctrl_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       state_i,
  input logic             clk_en_i,
  input logic             tgt_start_i,
  input logic             tgt_done_i,
  input logic             start_cmd_i,
  input logic             resume_cmd_i,
  input logic             halt_cmd_i,
  input logic [CNT_W-1:0] cnt_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R3
  en_only_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_i |-> state_i == 2'd1);

  // R2
  start_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_cmd_i |=> (state_i == 2'd1) && tgt_start_i && (cnt_i == '0));

  // R2
  start_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_start_i && clk_en_i && !start_cmd_i |=> !tgt_start_i);

  // R9
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_i && !start_cmd_i && (cnt_i != CNT_MAX) |=> cnt_i == $past(cnt_i) + 1'b1);

  // R9
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i && !start_cmd_i |=> $stable(cnt_i));

  // R7
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'd2) && !start_cmd_i && !resume_cmd_i |=> state_i == 2'd2);

  // R8
  resume_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'd2) && resume_cmd_i && !start_cmd_i |=> (state_i == 2'd1) && (clk_en_i || halt_cmd_i || start_cmd_i));

  // R6
  halt_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'd1) && halt_cmd_i && !start_cmd_i && !(tgt_done_i && !tgt_start_i) |=> state_i == 2'd2);

  // R10
  done_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'd1) && tgt_done_i && !tgt_start_i && !start_cmd_i |=> state_i == 2'd0);
endmodule

bind bp_clk_ctrl bp_clk_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_i(run_state),
  .clk_en_i(tgt_clk_en_o), .tgt_start_i(tgt_start_o), .tgt_done_i(tgt_done_i),
  .start_cmd_i(start_cmd), .resume_cmd_i(resume_cmd), .halt_cmd_i(halt_cmd),
  .cnt_i(cycle_cnt)
);

// File: tb/bp_clk_ctrl_test.sv
module bp_clk_ctrl_test;
  localparam int unsigned NP = 4, PW = 16, CW = 6, HW = 32;
  localparam logic [15:0] LIMIT = 16'd100;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          wr = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [HW-1:0] wdata = '0, rdata;
  logic          clk_en, tstart, tdone;
  logic [15:0]   tcnt;
  logic          trun;
  logic [NP*PW-1:0] probes;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bp_clk_ctrl #(.N_PROBE(NP), .PROBE_W(PW), .CNT_W(CW), .HOST_W(HW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(wr), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .tgt_clk_en_o(clk_en),
    .tgt_start_o(tstart), .tgt_done_i(tdone), .tgt_probe_i(probes)
  );

  // target model: counts on enabled cycles only
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0; trun <= 1'b0;
    end else if (clk_en) begin
      if (tstart) begin tcnt <= '0; trun <= 1'b1; end
      else if (trun && tcnt != LIMIT) tcnt <= tcnt + 16'd1;
    end
  end
  assign tdone  = trun && (tcnt == LIMIT);
  assign probes = {16'h0055, ~tcnt, tcnt * 16'd3, tcnt};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_state(input logic [1:0] st, input int maxc, output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      rd_reg(2'd0, v);
      if (v[1:0] == st) begin ok = 1'b1; break; end
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd_reg(2'd0, v); chk("R1 status", v, 0);
    rd_reg(2'd3, v); chk("R1 count", v, 0);
    rd_reg(2'd1, v); chk("R1 cfg", v, 0);
    rd_reg(2'd2, v); chk("R1 bpval", v, 0);
    chk("R1 clk_en", clk_en, 0);
    chk("R1 start", tstart, 0);
  endtask

  task automatic t_run_to_done;
    logic [31:0] v; bit ok;
    wr_reg(2'd0, 32'h1);
    rd_reg(2'd0, v); chk("R2 state run", v, 1);
    rd_reg(2'd3, v); chk("R2 count clear", v, 0);
    chk("R2 start out", tstart, 1);
    chk("R3 enable in run", clk_en, 1);
    @(negedge clk);
    chk("R2 start drops", tstart, 0);
    wait_state(2'd0, 300, ok);
    chk("R10 reached idle", ok, 1);
    rd_reg(2'd0, v); chk("R10 done flag", v, 32'h4);
    rd_reg(2'd3, v); chk("R9 saturated", v, 63);
    chk("R3 enable idle", clk_en, 0);
  endtask

  task automatic t_ignored_cmds;
    logic [31:0] v;
    wr_reg(2'd0, 32'h2);
    rd_reg(2'd0, v); chk("R8 resume ignored idle", v, 32'h4);
    chk("R8 no enable", clk_en, 0);
    wr_reg(2'd0, 32'h4);
    @(negedge clk);
    rd_reg(2'd0, v); chk("R6 halt ignored idle", v, 32'h4);
    rd_reg(2'd3, v); chk("R6 count unchanged", v, 63);
  endtask

  task automatic t_value_break;
    logic [31:0] v; bit ok;
    wr_reg(2'd1, 32'h100);
    wr_reg(2'd2, 32'd10);
    wr_reg(2'd0, 32'h1);
    wait_state(2'd2, 60, ok);
    chk("R4 halted", ok, 1);
    chk("R4 target holds match", tcnt, 10);
    rd_reg(2'd3, v); chk("R4 count at break", v, 11);
    rd_reg(2'd0, v); chk("R2 done flag cleared", v, 2);
    chk("R3 enable halted", clk_en, 0);
    repeat (5) @(negedge clk);
    chk("R7 target frozen", tcnt, 10);
    rd_reg(2'd3, v); chk("R7 count frozen", v, 11);
    rd_reg(2'd0, v); chk("R7 still halted", v, 2);
  endtask

  task automatic t_resume_mask;
    logic [31:0] v; bit ok;
    wr_reg(2'd0, 32'h2);
    rd_reg(2'd0, v); chk("R8 resumed", v, 1);
    chk("R8 match masked", clk_en, 1);
    @(negedge clk);
    chk("R8 target stepped", tcnt, 11);
    rd_reg(2'd3, v); chk("R8 count stepped", v, 12);
    rd_reg(2'd0, v); chk("R8 still run", v, 1);
    wait_state(2'd0, 300, ok);
    chk("R10 done after resume", ok, 1);
  endtask

  task automatic t_halt_cmd;
    logic [31:0] v;
    wr_reg(2'd1, 32'h0);
    wr_reg(2'd0, 32'h1);
    repeat (5) @(negedge clk);
    wr_reg(2'd0, 32'h4);
    rd_reg(2'd0, v); chk("R6 halted by host", v, 2);
    rd_reg(2'd3, v); chk("R6 count", v, 5);
    chk("R6 target value", tcnt, 4);
    chk("R6 enable low", clk_en, 0);
    wr_reg(2'd0, 32'h4);
    rd_reg(2'd3, v); chk("R7 count held", v, 5);
    wr_reg(2'd0, 32'h1);
    rd_reg(2'd0, v); chk("R2 restart from halt", v, 1);
    rd_reg(2'd3, v); chk("R2 restart count", v, 0);
    chk("R2 restart start", tstart, 1);
  endtask

  task automatic t_bp_disable;
    logic [31:0] v; bit seen_halt; bit ok;
    wr_reg(2'd2, 32'd5);
    wr_reg(2'd1, 32'h0);
    rd_reg(2'd2, v); chk("R11 bpval kept", v, 5);
    wr_reg(2'd0, 32'h1);
    seen_halt = 1'b0; ok = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      rd_reg(2'd0, v);
      if (v[1:0] == 2'd2) seen_halt = 1'b1;
      if (v[1:0] == 2'd0) begin ok = 1'b1; break; end
    end
    chk("R11 no halt when off", seen_halt, 0);
    chk("R11 run completed", ok, 1);
    wr_reg(2'd1, 32'h100);
    rd_reg(2'd2, v); chk("R11 bpval unchanged", v, 5);
    wr_reg(2'd0, 32'h1);
    wait_state(2'd2, 60, ok);
    chk("R11 re-enabled halt", ok, 1);
    chk("R11 halt value", tcnt, 5);
  endtask

  task automatic t_select;
    logic [31:0] v; bit ok;
    wr_reg(2'd1, 32'h101);
    wr_reg(2'd2, 32'd12);
    rd_reg(2'd1, v); chk("R5 cfg readback", v, 32'h101);
    wr_reg(2'd0, 32'h1);
    wait_state(2'd2, 60, ok);
    chk("R5 lane1 halted", ok, 1);
    chk("R5 lane1 value", tcnt, 4);
    rd_reg(2'd3, v); chk("R5 lane1 count", v, 5);
    wr_reg(2'd1, 32'h102);
    wr_reg(2'd2, 32'hFFF8);
    wr_reg(2'd0, 32'h2);
    wait_state(2'd2, 60, ok);
    chk("R5 lane2 halted", ok, 1);
    chk("R5 lane2 value", tcnt, 7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run_to_done();
    t_ignored_cmds();
    t_value_break();
    t_resume_mask();
    t_halt_cmd();
    t_bp_disable();
    t_select();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule